// File: doc/BRIEF.md
# Two-Level Interrupt Arbiter

This block collects five interrupt sources: two active-low external pins, two timer overflow pulses and a serial-port request line. Each source passes through a global gate and its own enable bit, and is placed at one of two priority levels. The block offers the CPU one request at a time, together with the index and entry address of the chosen source. The CPU answers with an acknowledge when it takes the interrupt and with a return strobe when the handler finishes. Three small registers hold the configuration and are reached through a byte-wide write port and a combinational read port.

The external pins can each be set to falling-edge mode, where a latched flag is set by the edge and cleared when its service is taken, or to level mode, where the flag tracks the inverted pin. Timer overflow pulses set latched flags that the acknowledge clears. The serial line is level-sensitive and must be cleared at its own source.

Service nesting is tracked by a four-state machine. `ST_IDLE` means no handler is running. `ST_LOW` means a low-level handler is running. `ST_HIGH` means a high-level handler started from idle. `ST_NESTED` means a high-level handler has pre-empted a low-level one. The transitions are as follows. From `ST_IDLE`, a taken low request goes to `ST_LOW` and a taken high request goes to `ST_HIGH`. From `ST_LOW`, a taken high request goes to `ST_NESTED` and a return goes to `ST_IDLE`. From `ST_HIGH`, a return goes to `ST_IDLE`. From `ST_NESTED`, a return goes to `ST_LOW`.

Top module: `irq_two_level`

## Requirements
- R1: After reset all three registers read 0 and `irq_req` is 0.
- R2: Each register is selected by a value on `reg_sel`. Select 0 is the enable register. Its bit 7 is the global gate and bits 4..0 enable the sources ext0, tmr0, ext1, tmr1, ser. Bit 5 is stored and bit 6 always reads 0. Select 1 is the priority register. Bits 4..0 are the sources in the same order (1 = high level), and bits 7..5 read 0. Select 2 is the external control register. Bit 3 is the ext1 flag, bit 2 the ext1 edge mode, bit 1 the ext0 flag and bit 0 the ext0 edge mode, and bits 7..4 read 0. A write to select 2 loads the flag bits of any input that is in edge mode. Select 3 reads 0.
- R3: While enable bit 7 is 0, `irq_req` stays 0 whatever else is pending.
- R4: A pending source whose enable bit is 0 never raises a request.
- R5: Among live sources of one level, the lowest index wins. The indices are ext0=0, tmr0=1, ext1=2, tmr1=3, ser=4. `irq_vec` equals 0x0003 + 8 × `irq_idx`.
- R6: A live high-level source is offered ahead of any live low-level source.
- R7: In edge mode, a 1→0 transition of an external pin sets its flag at the next clock edge. The flag then stays set when the pin rises again, and is cleared by an acknowledge of that source.
- R8: In level mode, the external flag equals the inverted pin one clock later, and an acknowledge does not clear it.
- R9: A one-cycle timer overflow pulse sets that timer's flag, and an acknowledge of that timer clears it. The serial request is not cleared by an acknowledge.
- R10: While a low-level handler runs, only high-level sources can raise a request. While any high-level handler runs, no request is raised.
- R11: A return from a nested handler resumes the low level, where low sources stay blocked. A return from a single handler goes back to idle.
- R12: An acknowledge with `irq_req` at 0 changes neither the flags nor the service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n | input | 2 | External interrupt pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses (bit 0 timer 0) |
| ser_irq | input | 1 | Serial-port request, level |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | 3 | Index of the offered source |
| irq_vec | output | 16 | Entry address of the offered source |
| irq_ack | input | 1 | CPU takes the offered interrupt |
| irq_ret | input | 1 | CPU returns from the current handler |

## Verification
The bench sweeps every combination of pending sources against every priority mask, and every pending set against every enable byte. This catches an arbiter that inverts the fixed order, which would show the wrong index and vector. It also catches one that lets a low source beat a high one, or one that ignores the global gate or a per-source mask. Directed sequences cover three more faults. The first is a flag that follows the pin in edge mode, which would lose the request once the pin rises. The second is a level flag cleared by the acknowledge. The third is a timer flag that survives its acknowledge, which would make the same request appear twice. The nesting sequence checks that a low request stays hidden during a nested high handler and after the first return. It also checks that a high request cannot pre-empt another high handler, and that a stray acknowledge does not move the state machine into a level that would then hide low requests.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 5;
    localparam int IDX_W = 3;

    localparam int SRC_EXT0 = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_EXT1 = 2;
    localparam int SRC_TMR1 = 3;
    localparam int SRC_SER  = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2,
        ST_NESTED = 2'd3
    } svc_state_t;

    localparam logic [1:0] SEL_ENABLE = 2'd0;
    localparam logic [1:0] SEL_PRIO   = 2'd1;
    localparam logic [1:0] SEL_EXTCTL = 2'd2;

    localparam int EN_GLOBAL_BIT = 7;
    localparam logic [7:0] EN_KEEP_MASK = 8'hBF;
endpackage

// File: rtl/irq_ext_latch.sv
module irq_ext_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic ack_clr,
    input  logic sw_we,
    input  logic sw_val,
    output logic flag
);
    logic pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
            flag  <= 1'b0;
        end else begin
            pin_q <= pin_n;
            if (edge_mode) begin
                if (pin_q && !pin_n)
                    flag <= 1'b1;
                else if (ack_clr)
                    flag <= 1'b0;
                else if (sw_we)
                    flag <= sw_val;
            end else begin
                flag <= !pin_n;
            end
        end
    end

    // R7: a falling edge in edge mode sets the flag
    p_edge_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && pin_q && !pin_n) |=> flag);

    // R8: in level mode the flag is the inverted pin one clock later
    p_level_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> (flag == !$past(pin_n)));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N  = irq_pkg::NSRC,
    parameter int IW = irq_pkg::IDX_W
) (
    input  logic [N-1:0]  live,
    input  logic [N-1:0]  hi_mask,
    input  logic          allow_lo,
    input  logic          allow_hi,
    output logic          req,
    output logic [IW-1:0] idx,
    output logic          sel_hi
);
    logic [N-1:0]  hi_set;
    logic [N-1:0]  lo_set;
    logic [IW-1:0] hi_idx;
    logic [IW-1:0] lo_idx;

    assign hi_set = live & hi_mask;
    assign lo_set = live & ~hi_mask;

    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hi_set[i]) hi_idx = IW'(i);
            if (lo_set[i]) lo_idx = IW'(i);
        end
    end

    always_comb begin
        req    = 1'b0;
        idx    = '0;
        sel_hi = 1'b0;
        if (allow_hi && (|hi_set)) begin
            req    = 1'b1;
            idx    = hi_idx;
            sel_hi = 1'b1;
        end else if (allow_lo && (|lo_set)) begin
            req    = 1'b1;
            idx    = lo_idx;
        end
    end
endmodule

// File: rtl/irq_level_fsm.sv
module irq_level_fsm
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       take_hi,
    input  logic       ret,
    output logic       allow_lo,
    output logic       allow_hi,
    output svc_state_t state
);
    svc_state_t state_q;
    svc_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take) state_d = take_hi ? ST_HIGH : ST_LOW;
            ST_LOW:    if (take && take_hi) state_d = ST_NESTED;
                       else if (ret) state_d = ST_IDLE;
            ST_HIGH:   if (ret) state_d = ST_IDLE;
            ST_NESTED: if (ret) state_d = ST_LOW;
        endcase
    end

    always_comb begin
        allow_lo = 1'b0;
        allow_hi = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin allow_lo = 1'b1; allow_hi = 1'b1; end
            ST_LOW:    allow_hi = 1'b1;
            ST_HIGH:   ;
            ST_NESTED: ;
        endcase
    end

    assign state = state_q;

    // R11: return from a nested handler resumes the low level
    p_nested_unwind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NESTED && ret) |=> (state_q == ST_LOW));

    // R11: return from a lone low handler goes back to idle
    p_low_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && ret && !take) |=> (state_q == ST_IDLE));

    // R12: no acknowledge taken, no return: state holds
    p_state_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !ret) |=> $stable(state_q));
endmodule

// File: rtl/irq_two_level.sv
module irq_two_level
    import irq_pkg::*;
#(
    parameter int               VEC_W       = 16,
    parameter logic [VEC_W-1:0] VEC_BASE    = 16'h0003,
    parameter int               VEC_STEP_LG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ext_n,
    input  logic [1:0]       tmr_ovf,
    input  logic             ser_irq,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq_req,
    output logic [IDX_W-1:0] irq_idx,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic             irq_ret
);
    logic [7:0]      en_r;
    logic [NSRC-1:0] prio_r;
    logic [1:0]      trig_r;
    logic [1:0]      ext_flag;
    logic [1:0]      tmr_flag;
    logic [1:0]      ext_clr;
    logic [1:0]      tmr_clr;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] live;
    logic            allow_lo;
    logic            allow_hi;
    logic            sel_hi;
    logic            take;
    svc_state_t      svc_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_r   <= '0;
            prio_r <= '0;
            trig_r <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                SEL_ENABLE: en_r   <= reg_wdata & EN_KEEP_MASK;
                SEL_PRIO:   prio_r <= reg_wdata[NSRC-1:0];
                SEL_EXTCTL: trig_r <= {reg_wdata[2], reg_wdata[0]};
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_ENABLE: reg_rdata = en_r;
            SEL_PRIO:   reg_rdata = {{(8-NSRC){1'b0}}, prio_r};
            SEL_EXTCTL: reg_rdata = {4'b0000, ext_flag[1], trig_r[1], ext_flag[0], trig_r[0]};
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign take = irq_ack && irq_req;

    for (genvar k = 0; k < 2; k++) begin : g_pair
        assign ext_clr[k] = take && (irq_idx == IDX_W'(2 * k));
        assign tmr_clr[k] = take && (irq_idx == IDX_W'(2 * k + 1));

        irq_ext_latch u_ext (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[k]),
            .edge_mode (trig_r[k]),
            .ack_clr   (ext_clr[k]),
            .sw_we     (reg_wr && reg_sel == SEL_EXTCTL),
            .sw_val    (reg_wdata[2 * k + 1]),
            .flag      (ext_flag[k])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            tmr_flag[k] <= 1'b0;
            else if (tmr_ovf[k])   tmr_flag[k] <= 1'b1;
            else if (tmr_clr[k])   tmr_flag[k] <= 1'b0;
        end

        // R9: acknowledge of a timer clears its flag
        p_timer_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_clr[k] && !tmr_ovf[k]) |=> !tmr_flag[k]);
    end

    assign pend = {ser_irq, tmr_flag[1], ext_flag[1], tmr_flag[0], ext_flag[0]};
    assign live = pend & en_r[NSRC-1:0] & {NSRC{en_r[EN_GLOBAL_BIT]}};

    irq_level_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_hi  (sel_hi),
        .ret      (irq_ret),
        .allow_lo (allow_lo),
        .allow_hi (allow_hi),
        .state    (svc_state)
    );

    irq_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
        .live     (live),
        .hi_mask  (prio_r),
        .allow_lo (allow_lo),
        .allow_hi (allow_hi),
        .req      (irq_req),
        .idx      (irq_idx),
        .sel_hi   (sel_hi)
    );

    assign irq_vec = VEC_BASE + (VEC_W'(irq_idx) << VEC_STEP_LG);

    // R3: no request while the global gate is off
    p_global_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_r[EN_GLOBAL_BIT] |-> !irq_req);

    // R4: the offered source is pending and enabled
    p_req_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> |(pend & en_r[NSRC-1:0] & (NSRC'(1) << irq_idx)));

    // R10: nothing is offered while a high-level handler runs
    p_busy_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_state == ST_HIGH || svc_state == ST_NESTED) |-> !irq_req);
endmodule

// File: tb/irq_two_level_test.sv
`timescale 1ns/1ps
module irq_two_level_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_n = 2'b11;
    logic [1:0] tmr_ovf = 2'b00;
    logic       ser_irq = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [2:0] irq_idx;
    logic [15:0] irq_vec;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_two_level uut (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
        .ser_irq(ser_irq), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_idx(irq_idx), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        cyc();
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output int v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse_tmr(input logic [1:0] m);
        cyc(); tmr_ovf = m;
        cyc(); tmr_ovf = 2'b00;
    endtask

    task automatic do_ack();
        cyc(); irq_ack = 1'b1;
        cyc(); irq_ack = 1'b0;
    endtask

    task automatic do_ret();
        cyc(); irq_ret = 1'b1;
        cyc(); irq_ret = 1'b0;
    endtask

    task automatic look(input string tag, input int req, input int idx);
        #1;
        chk({tag, " req"}, irq_req, req);
        if (req != 0) begin
            chk({tag, " idx"}, irq_idx, idx);
            chk({tag, " vec"}, irq_vec, 3 + 8 * idx);
        end
    endtask

    task automatic drain();
        ser_irq = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cyc(); #1;
            if (irq_req) begin
                do_ack();
                do_ret();
            end
        end
    endtask

    function automatic int lowest(input int m);
        for (int i = 0; i < 5; i++) if (m[i]) return i;
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        rd(2'd0, v); chk("R1 enable", v, 0);
        rd(2'd1, v); chk("R1 prio", v, 0);
        rd(2'd2, v); chk("R1 extctl", v, 0);
        chk("R1 req", irq_req, 0);

        // R2 register layout
        wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 enable bit6", v, 8'hBF);
        wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 prio upper", v, 8'h1F);
        wr(2'd2, 8'h05); wr(2'd2, 8'hFF); rd(2'd2, v); chk("R2 extctl", v, 8'h0F);
        rd(2'd3, v); chk("R2 sel3", v, 0);
        wr(2'd1, 8'h00);
        drain();
        wr(2'd2, 8'h05);

        // R5 R6: pending x priority sweep
        wr(2'd0, 8'h9F);
        for (int q = 0; q < 32; q++) begin
            wr(2'd1, 8'(q));
            for (int p = 0; p < 32; p++) begin
                int hi, lo, e;
                wr(2'd2, {4'b0, p[2], 1'b1, p[0], 1'b1});
                pulse_tmr({p[3], p[1]});
                ser_irq = p[4];
                cyc();
                hi = p & q; lo = p & ~q & 31;
                e = (hi != 0) ? lowest(hi) : lowest(lo);
                look($sformatf("R5 R6 p=%0h q=%0h", p, q), (p != 0) ? 1 : 0, e);
                drain();
            end
        end

        // R3 R4: enable sweep with everything pending
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h0F);
        pulse_tmr(2'b11);
        ser_irq = 1'b1;
        for (int e = 0; e < 256; e++) begin
            int m;
            wr(2'd0, 8'(e));
            rd(2'd0, v); chk("R2 enable readback", v, e & 8'hBF);
            m = e[7] ? (e & 31) : 0;
            look($sformatf("R3 R4 en=%0h", e), (m != 0) ? 1 : 0, lowest(m));
        end
        wr(2'd0, 8'h9F);
        drain();

        // R7 edge mode
        wr(2'd0, 8'h81); wr(2'd2, 8'h01);
        cyc(); ext_n[0] = 1'b0;
        cyc(); rd(2'd2, v); chk("R7 flag set", v, 8'h03);
        ext_n[0] = 1'b1;
        cyc(); rd(2'd2, v); chk("R7 flag held", v, 8'h03);
        look("R7 req", 1, 0);
        do_ack(); rd(2'd2, v); chk("R7 ack clears", v, 8'h01);
        do_ret(); look("R7 after ret", 0, 0);

        // R8 level mode
        wr(2'd2, 8'h00);
        cyc(); ext_n[0] = 1'b0;
        cyc(); rd(2'd2, v); chk("R8 flag follows", v, 8'h02);
        do_ack(); do_ret();
        rd(2'd2, v); chk("R8 ack keeps", v, 8'h02);
        look("R8 req kept", 1, 0);
        ext_n[0] = 1'b1;
        cyc(); rd(2'd2, v); chk("R8 flag drops", v, 8'h00);
        look("R8 req gone", 0, 0);

        // R9 timer and serial
        wr(2'd0, 8'h82);
        pulse_tmr(2'b01); look("R9 timer", 1, 1);
        do_ack(); do_ret(); look("R9 timer cleared", 0, 0);
        wr(2'd0, 8'h90);
        cyc(); ser_irq = 1'b1; cyc(); look("R9 serial", 1, 4);
        do_ack(); do_ret(); look("R9 serial kept", 1, 4);
        ser_irq = 1'b0;

        // R10 R11 nesting
        wr(2'd0, 8'h8F); wr(2'd1, 8'h01); wr(2'd2, 8'h05);
        pulse_tmr(2'b10); look("R11 low offered", 1, 3);
        do_ack(); look("R10 low busy", 0, 0);
        pulse_tmr(2'b01); look("R10 low blocked", 0, 0);
        wr(2'd2, 8'h07); look("R10 high preempts", 1, 0);
        do_ack(); look("R10 nested blocks", 0, 0);
        do_ret(); look("R11 back to low", 0, 0);
        do_ret(); look("R11 back to idle", 1, 1);
        do_ack(); do_ret(); look("R11 drained", 0, 0);
        wr(2'd2, 8'h07); do_ack();
        wr(2'd2, 8'h07); look("R10 high not preempted", 0, 0);
        do_ret(); look("R10 high after ret", 1, 0);
        drain();

        // R12 stray acknowledge
        do_ack();
        pulse_tmr(2'b10); look("R12 stray ack ignored", 1, 3);
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule